// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This block sits between a small set of requesters and one shared, word-addressed memory. Each requester presents an operation over a valid/ready handshake. The block runs one operation at a time. Every operation is a fixed read-then-maybe-write sequence, so no other requester can reach the memory between the read of a word and its update. Plain reads and writes travel the same path as the atomic operations.

Four indivisible operations are provided: test-and-set, test-and-exchange, load-reserve and store-conditional. Each requester owns one reservation register. Load-reserve arms that register. Store-conditional consumes it. Any store to the reserved word, whichever requester makes it, breaks the reservation. A requester can use this pair to build a lock-free update with any amount of unrelated traffic in between. It can also use test-and-set as a simple spin lock.

Top module: `atomic_mem_unit`

## Requirements
- R1: After reset, no response is valid and no memory access is made, and every reservation is clear: a store-conditional as the first operation fails and leaves memory unchanged.
- R2: Test-and-set (opcode 2) returns the old word. It writes the request's write data only when the old word is zero. The success flag equals (old word == 0).
- R3: Test-and-exchange (opcode 3) returns the old word. It writes the register value into memory only when that register value is zero. The success flag is set only when the exchange took place.
- R4: Load-reserve (opcode 4) returns the word with success set and records the address for that requester. A later store-conditional (opcode 5) to that address succeeds and writes, even if any number of other operations that do not write the address come in between.
- R5: A store-conditional without a valid reservation, or with a reservation for a different address, returns success clear and leaves memory unchanged.
- R6: A store-conditional clears the issuing requester's reservation whether it succeeds or fails, so a second store-conditional fails.
- R7: Any write that takes effect at a reserved address clears every reservation for that address. This covers plain writes, test-and-set, test-and-exchange and store-conditional. An atomic operation whose test fails does not write, and so does not clear the reservation.
- R8: Each operation reads its word, and the only write it may make goes to the same address in the cycle right after that read. No other access occurs while a response is being presented.
- R9: Arbitration is round-robin, starting from requester 0 after reset. At most one request is accepted per operation. The response arrives on the one-hot response valid of the accepted requester exactly three cycles after the handshake.
- R10: A plain read (opcode 0) returns the word with success set. A plain write (opcode 1) stores the write data, returns the old word and sets success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | N | Request valid, one bit per requester |
| req_ready | output | N | Request accepted, one-hot |
| req_op | input | 3*N | Opcode per requester (0 read, 1 write, 2 test-and-set, 3 test-and-exchange, 4 load-reserve, 5 store-conditional) |
| req_addr | input | AW*N | Word address per requester |
| req_wdata | input | DW*N | Write data per requester |
| req_rval | input | DW*N | Register value per requester, used by test-and-exchange |
| rsp_valid | output | N | Response valid, one-hot by requester |
| rsp_rdata | output | DW | Old memory word |
| rsp_ok | output | 1 | Success flag |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after a read |

## Verification
The bench goes after the corners where a reservation must and must not survive, each of which would show up at the ports.

- **Intervening traffic:** reads and writes to other addresses sit between load-reserve and store-conditional. A design that broke reservations on any traffic would fail that store-conditional.
- **Failed atomic test:** a test-and-set whose test fails lands on a reserved word. A design that cleared reservations on attempted rather than performed writes would turn the later success into a failure.
- **Two holders, one store:** two requesters hold reservations on the same word when a third one stores to it. Both store-conditionals must fail, and memory must keep the third requester's value.
- **Repeated and mismatched store-conditional:** a store-conditional is repeated, and another targets a different address than the one reserved. A design that forgot to consume the reservation would write memory twice.
- **Simultaneous requests:** several requests are raised in the same cycle. A fixed-priority arbiter would return the responses in the wrong order.

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit #(
  parameter int N  = 3,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req_valid,
  output logic [N-1:0]    req_ready,
  input  logic [3*N-1:0]  req_op,
  input  logic [AW*N-1:0] req_addr,
  input  logic [DW*N-1:0] req_wdata,
  input  logic [DW*N-1:0] req_rval,
  output logic [N-1:0]    rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  output logic            rsp_ok,
  output logic            mem_en,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [2:0] OP_RD = 3'd0, OP_WR = 3'd1, OP_TAS = 3'd2,
                         OP_TXC = 3'd3, OP_LR = 3'd4, OP_SC = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_EVAL, S_RESP} state_t;
  state_t state;

  logic [IW-1:0] last_q, own_q, pick;
  logic          pick_any;
  logic [2:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rval_q, old_q;
  logic          ok_q;
  logic [N-1:0]  rv_q;
  logic [AW-1:0] ra_q [N];

  logic          do_wr, ok_c;
  logic [DW-1:0] wval;
  logic          hit;

  always_comb begin
    pick = '0;
    pick_any = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(last_q) + k) % N;
      if (!pick_any && req_valid[idx]) begin
        pick = IW'(idx);
        pick_any = 1'b1;
      end
    end
  end

  always_comb begin
    req_ready = '0;
    if (state == S_IDLE && pick_any) req_ready[pick] = 1'b1;
  end

  assign hit = rv_q[own_q] && (ra_q[own_q] == addr_q);

  always_comb begin
    do_wr = 1'b0;
    ok_c  = 1'b1;
    wval  = wdata_q;
    case (op_q)
      OP_WR:  do_wr = 1'b1;
      OP_TAS: begin do_wr = (mem_rdata == '0); ok_c = do_wr; end
      OP_TXC: begin do_wr = (rval_q == '0); ok_c = do_wr; wval = rval_q; end
      OP_SC:  begin do_wr = hit; ok_c = hit; end
      default: ;
    endcase
  end

  assign mem_en    = (state == S_READ) || (state == S_EVAL && do_wr);
  assign mem_we    = (state == S_EVAL);
  assign mem_addr  = addr_q;
  assign mem_wdata = wval;

  always_comb begin
    rsp_valid = '0;
    if (state == S_RESP) rsp_valid[own_q] = 1'b1;
  end
  assign rsp_rdata = old_q;
  assign rsp_ok    = ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      last_q  <= IW'(N - 1);
      own_q   <= '0;
      op_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rval_q  <= '0;
      old_q   <= '0;
      ok_q    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (pick_any) begin
          state   <= S_READ;
          own_q   <= pick;
          last_q  <= pick;
          op_q    <= req_op[3*pick +: 3];
          addr_q  <= req_addr[AW*pick +: AW];
          wdata_q <= req_wdata[DW*pick +: DW];
          rval_q  <= req_rval[DW*pick +: DW];
        end
        S_READ: state <= S_EVAL;
        S_EVAL: begin
          state <= S_RESP;
          old_q <= mem_rdata;
          ok_q  <= ok_c;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= '0;
      for (int j = 0; j < N; j++) ra_q[j] <= '0;
    end else if (state == S_EVAL) begin
      for (int j = 0; j < N; j++) begin
        if (do_wr && ra_q[j] == addr_q) rv_q[j] <= 1'b0;
        if (IW'(j) == own_q && op_q == OP_SC) rv_q[j] <= 1'b0;
        if (IW'(j) == own_q && op_q == OP_LR) begin
          rv_q[j] <= 1'b1;
          ra_q[j] <= addr_q;
        end
      end
    end
  end
endmodule

// File: rtl/atomic_mem_unit_chk.sv
module atomic_mem_unit_chk #(
  parameter int N  = 3,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  req_ready,
  input logic [N-1:0]  rsp_valid,
  input logic          mem_en,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr
);
  p_grant_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  p_rsp_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_valid));

  p_rsp_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ready) |-> ##3 (rsp_valid == $past(req_ready, 3)));

  p_write_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> ($past(mem_en && !mem_we) && $stable(mem_addr)));

  p_quiet_on_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_valid) |-> !mem_en);

  p_quiet_on_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ready) |-> !mem_en);
endmodule

bind atomic_mem_unit atomic_mem_unit_chk #(.N(N), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr));

// File: tb/atomic_mem_unit_test.sv
module atomic_mem_unit_test;
  localparam int N = 3, AW = 4, DW = 16, DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0]    req_valid = '0, req_ready, rsp_valid;
  logic [2:0]      op_a [N];
  logic [AW-1:0]   ad_a [N];
  logic [DW-1:0]   wd_a [N], rv_a [N];
  logic [3*N-1:0]  req_op;
  logic [AW*N-1:0] req_addr;
  logic [DW*N-1:0] req_wdata, req_rval;
  logic [DW-1:0]   rsp_rdata, mem_wdata, mem_rdata;
  logic            rsp_ok, mem_en, mem_we;
  logic [AW-1:0]   mem_addr;

  always_comb
    for (int i = 0; i < N; i++) begin
      req_op[3*i +: 3]     = op_a[i];
      req_addr[AW*i +: AW] = ad_a[i];
      req_wdata[DW*i +: DW] = wd_a[i];
      req_rval[DW*i +: DW]  = rv_a[i];
    end

  atomic_mem_unit #(.N(N), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_rval(req_rval),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_ok(rsp_ok),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  logic [DW-1:0] ram [DEPTH];
  initial for (int i = 0; i < DEPTH; i++) ram[i] = '0;
  always_ff @(posedge clk)
    if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else mem_rdata <= ram[mem_addr];
    end

  typedef struct {
    int            id;
    logic [DW-1:0] data;
    logic          ok;
    string         tag;
  } item_t;
  item_t sb [$];

  int checks = 0, fails = 0;
  logic [DW-1:0] m_mem [DEPTH];
  logic          m_rv [N];
  logic [AW-1:0] m_ra [N];
  initial for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
  initial for (int i = 0; i < N; i++) begin m_rv[i] = 1'b0; m_ra[i] = '0; end

  task automatic expect_op(int id, logic [2:0] op, logic [AW-1:0] a,
                           logic [DW-1:0] wd, logic [DW-1:0] rv, string tag);
    item_t it;
    logic wr;
    logic [DW-1:0] val;
    it.id = id; it.data = m_mem[a]; it.ok = 1'b1; it.tag = tag;
    wr = 1'b0; val = wd;
    case (op)
      3'd1: wr = 1'b1;
      3'd2: begin wr = (m_mem[a] == '0); it.ok = wr; end
      3'd3: begin wr = (rv == '0); it.ok = wr; val = rv; end
      3'd4: begin m_rv[id] = 1'b1; m_ra[id] = a; end
      3'd5: begin wr = m_rv[id] && m_ra[id] == a; it.ok = wr; m_rv[id] = 1'b0; end
      default: ;
    endcase
    if (wr) begin
      m_mem[a] = val;
      for (int j = 0; j < N; j++) if (m_ra[j] == a) m_rv[j] = 1'b0;
    end
    sb.push_back(it);
  endtask

  task automatic drive_op(int id, logic [2:0] op, logic [AW-1:0] a,
                          logic [DW-1:0] wd, logic [DW-1:0] rv);
    @(negedge clk);
    op_a[id] = op; ad_a[id] = a; wd_a[id] = wd; rv_a[id] = rv;
    req_valid[id] = 1'b1;
    forever begin
      #1;
      if (req_ready[id]) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid[id] = 1'b0;
  endtask

  task automatic wait_idle();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_op(int id, logic [2:0] op, logic [AW-1:0] a,
                       logic [DW-1:0] wd, logic [DW-1:0] rv, string tag);
    expect_op(id, op, a, wd, rv, tag);
    drive_op(id, op, a, wd, rv);
    wait_idle();
  endtask

  always @(negedge clk)
    if (rst_n && rsp_valid != '0) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL unexpected response: rsp_valid=%b expected none", rsp_valid);
      end else begin
        item_t e;
        e = sb.pop_front();
        if (rsp_valid != N'(1 << e.id) || rsp_rdata != e.data || rsp_ok != e.ok) begin
          fails++;
          $display("FAIL %s: valid=%b data=%h ok=%b, expected valid=%b data=%h ok=%b",
                   e.tag, rsp_valid, rsp_rdata, rsp_ok, N'(1 << e.id), e.data, e.ok);
        end
      end
    end

  initial begin
    for (int i = 0; i < N; i++) begin
      op_a[i] = '0; ad_a[i] = '0; wd_a[i] = '0; rv_a[i] = '0;
    end
    fork
      begin : body
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid != '0 || mem_en || req_ready != '0) begin
          fails++;
          $display("FAIL R1 reset: rsp_valid=%b mem_en=%b ready=%b expected 0 0 0",
                   rsp_valid, mem_en, req_ready);
        end
        rst_n = 1'b1;
        // R1 / R5: store-conditional straight after reset fails
        do_op(0, 3'd5, 4'd3, 16'h1234, 16'h0, "R1");
        do_op(0, 3'd0, 4'd3, 16'h0, 16'h0, "R1");
        // R10 plain read and write
        do_op(1, 3'd1, 4'd5, 16'h0042, 16'h0, "R10");
        do_op(2, 3'd0, 4'd5, 16'h0, 16'h0, "R10");
        do_op(1, 3'd1, 4'd5, 16'h0000, 16'h0, "R10");
        // R2 test-and-set
        do_op(0, 3'd2, 4'd5, 16'h00AA, 16'h0, "R2");
        do_op(1, 3'd2, 4'd5, 16'h00BB, 16'h0, "R2");
        do_op(2, 3'd0, 4'd5, 16'h0, 16'h0, "R2");
        // R3 test-and-exchange
        do_op(2, 3'd3, 4'd5, 16'h0, 16'h0000, "R3");
        do_op(1, 3'd0, 4'd5, 16'h0, 16'h0, "R3");
        do_op(0, 3'd1, 4'd6, 16'h0011, 16'h0, "R3");
        do_op(2, 3'd3, 4'd6, 16'h0, 16'h0055, "R3");
        do_op(1, 3'd0, 4'd6, 16'h0, 16'h0, "R3");
        // R4 reservation survives unrelated traffic
        do_op(1, 3'd1, 4'd7, 16'h0077, 16'h0, "R4");
        do_op(0, 3'd4, 4'd7, 16'h0, 16'h0, "R4");
        do_op(1, 3'd0, 4'd7, 16'h0, 16'h0, "R4");
        do_op(2, 3'd1, 4'd8, 16'h0088, 16'h0, "R4");
        do_op(1, 3'd2, 4'd9, 16'h0009, 16'h0, "R4");
        do_op(0, 3'd5, 4'd7, 16'h0099, 16'h0, "R4");
        do_op(2, 3'd0, 4'd7, 16'h0, 16'h0, "R4");
        // R6 reservation consumed; R5 address mismatch
        do_op(0, 3'd5, 4'd7, 16'h0111, 16'h0, "R6");
        do_op(1, 3'd4, 4'd10, 16'h0, 16'h0, "R5");
        do_op(1, 3'd5, 4'd11, 16'h0BAD, 16'h0, "R5");
        do_op(1, 3'd5, 4'd10, 16'h0BAD, 16'h0, "R6");
        do_op(2, 3'd0, 4'd11, 16'h0, 16'h0, "R5");
        do_op(2, 3'd0, 4'd10, 16'h0, 16'h0, "R6");
        // R7 other writers break reservations
        do_op(0, 3'd4, 4'd12, 16'h0, 16'h0, "R7");
        do_op(2, 3'd4, 4'd12, 16'h0, 16'h0, "R7");
        do_op(1, 3'd1, 4'd12, 16'h00CC, 16'h0, "R7");
        do_op(0, 3'd5, 4'd12, 16'h0E0E, 16'h0, "R7");
        do_op(2, 3'd5, 4'd12, 16'h0F0F, 16'h0, "R7");
        do_op(1, 3'd0, 4'd12, 16'h0, 16'h0, "R7");
        do_op(0, 3'd4, 4'd13, 16'h0, 16'h0, "R7");
        do_op(1, 3'd2, 4'd13, 16'h0001, 16'h0, "R7");
        do_op(0, 3'd5, 4'd13, 16'h0D0D, 16'h0, "R7");
        do_op(1, 3'd1, 4'd14, 16'h0044, 16'h0, "R7");
        do_op(2, 3'd4, 4'd14, 16'h0, 16'h0, "R7");
        do_op(1, 3'd2, 4'd14, 16'h0002, 16'h0, "R7");
        do_op(2, 3'd5, 4'd14, 16'h0144, 16'h0, "R7");
        do_op(0, 3'd0, 4'd14, 16'h0, 16'h0, "R7");
        // R9 round-robin: last grant went to requester 0
        expect_op(1, 3'd0, 4'd7, 16'h0, 16'h0, "R9");
        expect_op(2, 3'd0, 4'd9, 16'h0, 16'h0, "R9");
        expect_op(0, 3'd0, 4'd5, 16'h0, 16'h0, "R9");
        fork
          drive_op(0, 3'd0, 4'd5, 16'h0, 16'h0);
          drive_op(1, 3'd0, 4'd7, 16'h0, 16'h0);
          drive_op(2, 3'd0, 4'd9, 16'h0, 16'h0);
        join
        wait_idle();
        // last grant 0: with 0 and 2 pending, 2 goes first
        expect_op(2, 3'd2, 4'd15, 16'h0003, 16'h0, "R9");
        expect_op(0, 3'd2, 4'd15, 16'h0004, 16'h0, "R9");
        fork
          drive_op(0, 3'd2, 4'd15, 16'h0004, 16'h0);
          drive_op(2, 3'd2, 4'd15, 16'h0003, 16'h0);
        join
        wait_idle();
        do_op(1, 3'd0, 4'd15, 16'h0, 16'h0, "R9");
      end
      begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule